// File: doc/BRIEF.md
# Packed SIMD Variable Arithmetic Shifter

This unit takes a 512-bit vector of signed elements and shifts each element right arithmetically by its own count, which it takes from the matching element of a second 512-bit vector. One datapath handles 16-bit, 32-bit and 64-bit elements. The active vector length can be 128, 256 or 512 bits. A count too large for the element width gives a lane filled entirely with its sign bit.

A per-lane write mask can be switched on. Lanes whose mask bit is clear then either keep the matching lane of a supplied previous-destination vector or are cleared to zero. For 32-bit and 64-bit elements, a broadcast option applies the lowest count element to every lane. Every bit above the active length is always zero.

The unit computes its result from the inputs present on an input-valid strobe. It registers that result and raises an output-valid flag on the next clock edge. The unit has no status or flag outputs.

Top module: `vsar_unit`

## Requirements
- R1: Each active lane of the result equals the source lane shifted right arithmetically by the lane's count, with vacated high bits taken from the source sign bit. The element width is set by `elem_sel`: 0 selects 16 bits, 1 selects 32 bits, and 2 or 3 select 64 bits. Lane j occupies bits j*W to j*W+W-1.
- R2: The whole count lane is read as an unsigned number of W bits. When that number exceeds W-1, every bit of the result lane equals the source lane's sign bit.
- R3: `vlen_sel` sets the active length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. Every result bit at or above the active length is zero, whatever the mask settings.
- R4: With `mask_en` low, every active lane receives its shifted value, whatever `lane_mask` holds. With `mask_en` high, bit j of `lane_mask` governs lane j, and a set bit passes the shifted value.
- R5: With `mask_en` high, `zero_mode` low and mask bit j clear, active lane j equals lane j of `prev_in`.
- R6: With `mask_en` high, `zero_mode` high and mask bit j clear, active lane j is zero.
- R7: Mask bits at or above the active lane count have no effect on the result.
- R8: With `bcast_en` high and 32-bit or 64-bit elements, lane 0 of `cnt_in` supplies the count for every lane, and the per-lane counts are not used.
- R9: With 16-bit elements, `bcast_en` is ignored and per-lane counts are used.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result computed from the inputs of that strobe appears on `result` on the same clock edge.
- R11: A synchronous reset clears `out_valid` and `result` to zero.
- R12: While `in_valid` is low, `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for all operands and controls |
| data_in | input | 512 | Signed source elements |
| cnt_in | input | 512 | Unsigned shift counts, one per element |
| prev_in | input | 512 | Previous destination value, used by merging |
| lane_mask | input | 32 | Per-lane write mask, bit j for lane j |
| elem_sel | input | 2 | Element width: 0=16, 1=32, 2/3=64 |
| vlen_sel | input | 2 | Active length: 0=128, 1=256, 2/3=512 |
| mask_en | input | 1 | Apply lane_mask |
| zero_mode | input | 1 | Masked-off lanes zeroed (1) or merged (0) |
| bcast_en | input | 1 | Lowest count element applies to all lanes (32/64-bit only) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 512 | Registered shifted vector |

## Verification
The datapath is combinational up to a single result register, so a wrong lane pick, count pick or mask decision shows on `result` in the cycle that `out_valid` rises. No fault is ever hidden behind later state. The bench compares each result with a lane-by-lane model across all three widths, all three lengths, both mask modes and broadcast. Counts are chosen so that some lanes saturate and some shift normally. A wrong register enable would show as a result that changes, or an `out_valid` that stays high, during cycles without a strobe. A faulty reset would show as a nonzero `result` immediately after reset.

// File: rtl/vsar_pkg.sv
package vsar_pkg;

    localparam int VEC_BITS   = 512;
    localparam int MASK_BITS  = 32;
    localparam int CHUNK_BITS = 16;
    localparam int NUM_WIDTHS = 3;

    typedef enum logic [1:0] {
        ELEM_H     = 2'd0,
        ELEM_S     = 2'd1,
        ELEM_D     = 2'd2,
        ELEM_D_ALT = 2'd3
    } elem_e;

    typedef enum logic [1:0] {
        LEN_128     = 2'd0,
        LEN_256     = 2'd1,
        LEN_512     = 2'd2,
        LEN_512_ALT = 2'd3
    } vlen_e;

    typedef struct packed {
        elem_e elem;
        vlen_e vlen;
        logic  mask_en;
        logic  zero_mode;
    } merge_ctrl_t;

    // index of the width bank that serves an element encoding
    function automatic logic [1:0] bank_of(elem_e e);
        case (e)
            ELEM_H:  return 2'd0;
            ELEM_S:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // number of 16-bit chunks inside the active length
    function automatic int active_chunks(vlen_e v, int vec_w);
        case (v)
            LEN_128: return 128 / CHUNK_BITS;
            LEN_256: return 256 / CHUNK_BITS;
            default: return vec_w / CHUNK_BITS;
        endcase
    endfunction

endpackage

// File: rtl/vsar_lane.sv
module vsar_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] dout
);
    localparam int LOG_W = $clog2(W);

    logic over_range;
    assign over_range = |cnt[W-1:LOG_W];

    always_comb begin
        if (over_range)
            dout = {W{din[W-1]}};
        else
            dout = W'($signed(din) >>> cnt[LOG_W-1:0]);
    end
endmodule

// File: rtl/vsar_width_bank.sv
module vsar_width_bank #(
    parameter int W     = 64,
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] data_in,
    input  logic [VEC_W-1:0] cnt_in,
    input  logic             bcast_en,
    output logic [VEC_W-1:0] shifted
);
    localparam int  NUM_LANES = VEC_W / W;
    localparam bit  HAS_BCAST = (W > 16);

    logic use_bcast;
    assign use_bcast = HAS_BCAST && bcast_en;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [W-1:0] lane_cnt;
        assign lane_cnt = use_bcast ? cnt_in[W-1:0] : cnt_in[l*W +: W];

        vsar_lane #(.W(W)) u_lane (
            .din  (data_in[l*W +: W]),
            .cnt  (lane_cnt),
            .dout (shifted[l*W +: W])
        );
    end
endmodule

// File: rtl/vsar_lane_select.sv
module vsar_lane_select
    import vsar_pkg::*;
#(
    parameter int VEC_W  = VEC_BITS,
    parameter int MASK_W = MASK_BITS
) (
    input  logic [NUM_WIDTHS-1:0][VEC_W-1:0] banks,
    input  logic [VEC_W-1:0]                 prev_in,
    input  logic [MASK_W-1:0]                lane_mask,
    input  merge_ctrl_t                      ctrl,
    output logic [VEC_W-1:0]                 merged
);
    localparam int NCH = VEC_W / CHUNK_BITS;

    logic [1:0] bidx;
    int         act_n;

    always_comb begin
        bidx  = bank_of(ctrl.elem);
        act_n = active_chunks(ctrl.vlen, VEC_W);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        localparam int M16 = (c     < MASK_W) ? c     : MASK_W - 1;
        localparam int M32 = (c / 2 < MASK_W) ? c / 2 : MASK_W - 1;
        localparam int M64 = (c / 4 < MASK_W) ? c / 4 : MASK_W - 1;

        logic                  mbit;
        logic                  active;
        logic [CHUNK_BITS-1:0] pick;

        always_comb begin
            case (bidx)
                2'd0:    mbit = lane_mask[M16];
                2'd1:    mbit = lane_mask[M32];
                default: mbit = lane_mask[M64];
            endcase
            active = (c < act_n);
            pick   = banks[bidx][c*CHUNK_BITS +: CHUNK_BITS];

            if (!active)
                merged[c*CHUNK_BITS +: CHUNK_BITS] = '0;
            else if (!ctrl.mask_en || mbit)
                merged[c*CHUNK_BITS +: CHUNK_BITS] = pick;
            else if (ctrl.zero_mode)
                merged[c*CHUNK_BITS +: CHUNK_BITS] = '0;
            else
                merged[c*CHUNK_BITS +: CHUNK_BITS] = prev_in[c*CHUNK_BITS +: CHUNK_BITS];
        end
    end
endmodule

// File: rtl/vsar_unit.sv
module vsar_unit
    import vsar_pkg::*;
#(
    parameter int VEC_W  = VEC_BITS,
    parameter int MASK_W = MASK_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  data_in,
    input  logic [VEC_W-1:0]  cnt_in,
    input  logic [VEC_W-1:0]  prev_in,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic [1:0]        elem_sel,
    input  logic [1:0]        vlen_sel,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              bcast_en,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    logic [NUM_WIDTHS-1:0][VEC_W-1:0] banks;
    logic [VEC_W-1:0]                 next_res;
    merge_ctrl_t                      ctrl;

    always_comb begin
        ctrl.elem      = elem_e'(elem_sel);
        ctrl.vlen      = vlen_e'(vlen_sel);
        ctrl.mask_en   = mask_en;
        ctrl.zero_mode = zero_mode;
    end

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_bank
        vsar_width_bank #(.W(16 << g), .VEC_W(VEC_W)) u_bank (
            .data_in  (data_in),
            .cnt_in   (cnt_in),
            .bcast_en (bcast_en),
            .shifted  (banks[g])
        );
    end

    vsar_lane_select #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_sel (
        .banks     (banks),
        .prev_in   (prev_in),
        .lane_mask (lane_mask),
        .ctrl      (ctrl),
        .merged    (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end
endmodule

// File: rtl/vsar_unit_chk.sv
module vsar_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   elem_sel,
    input logic [1:0]   vlen_sel,
    input logic         mask_en,
    input logic         zero_mode,
    input logic         bcast_en,
    input logic         mask0,
    input logic [57:0]  cnt_hi,
    input logic         dsign,
    input logic [15:0]  prev_lo,
    input logic         out_valid,
    input logic [63:0]  res_lo,
    input logic [383:0] res_hi
);
    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && res_lo == 64'd0 && res_hi == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'd0) |=> res_hi == '0);

    p_merge_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !zero_mode && !mask0) |=> res_lo[15:0] == $past(prev_lo));

    p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && zero_mode && !mask0) |=> res_lo[15:0] == 16'd0);

    p_sat_sign_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_sel == 2'd2 && !bcast_en && (!mask_en || mask0) && cnt_hi != '0)
        |=> res_lo == {64{$past(dsign)}});
endmodule

bind vsar_unit vsar_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .elem_sel  (elem_sel),
    .vlen_sel  (vlen_sel),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .bcast_en  (bcast_en),
    .mask0     (lane_mask[0]),
    .cnt_hi    (cnt_in[63:6]),
    .dsign     (data_in[63]),
    .prev_lo   (prev_in[15:0]),
    .out_valid (out_valid),
    .res_lo    (result[63:0]),
    .res_hi    (result[511:128])
);

// File: tb/vsar_unit_tb.sv
module vsar_unit_tb;

    typedef struct packed {
        logic [1:0]  elem;
        logic [1:0]  vlen;
        logic        men;
        logic        zm;
        logic        bc;
        logic        big;
        logic [31:0] mask;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'd11},
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'd12},
        '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'd13},
        '{2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'd14},
        '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'd15},
        '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd16},
        '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd17},
        '{2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'hA5C3_0F96, 32'd18},
        '{2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_5A3C, 32'd19},
        '{2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0006, 32'd20},
        '{2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_00B2, 32'd21},
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'd22},
        '{2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_006D, 32'd23},
        '{2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'd24}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] data_in = '0;
    logic [511:0] cnt_in = '0;
    logic [511:0] prev_in = '0;
    logic [31:0]  lane_mask = '0;
    logic [1:0]   elem_sel = 2'd0;
    logic [1:0]   vlen_sel = 2'd2;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast_en = 1'b0;
    logic         out_valid;
    logic [511:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vsar_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .data_in   (data_in),
        .cnt_in    (cnt_in),
        .prev_in   (prev_in),
        .lane_mask (lane_mask),
        .elem_sel  (elem_sel),
        .vlen_sel  (vlen_sel),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .bcast_en  (bcast_en),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] nxt(logic [63:0] s);
        return s * 64'd6364136223846793005 + 64'd1442695040888963407;
    endfunction

    function automatic int width_of(logic [1:0] e);
        return (e == 2'd0) ? 16 : (e == 2'd1) ? 32 : 64;
    endfunction

    function automatic logic [511:0] fill(logic [63:0] seed);
        logic [511:0] r;
        logic [63:0]  s;
        s = seed;
        for (int q = 0; q < 8; q++) begin
            s = nxt(s);
            r[q*64 +: 64] = s;
        end
        return r;
    endfunction

    function automatic logic [511:0] mk_cnt(logic [1:0] e, logic [63:0] seed, logic big);
        logic [511:0] r;
        logic [63:0]  s;
        logic [63:0]  lv;
        int           w;
        w = width_of(e);
        r = '0;
        s = seed ^ 64'h5555_AAAA_0F0F_F0F0;
        for (int l = 0; l < 512 / w; l++) begin
            s  = nxt(s);
            lv = 64'(s[47:32] % 16'(w + 8));
            if (big && (l % 3 == 2))
                lv[w-1] = 1'b1;
            for (int b = 0; b < w; b++)
                r[l*w + b] = lv[b];
        end
        return r;
    endfunction

    function automatic logic [511:0] model(logic [1:0] e, logic [1:0] v, logic men, logic zm,
                                           logic bc, logic [31:0] m,
                                           logic [511:0] d, logic [511:0] c, logic [511:0] p);
        logic [511:0] r;
        logic [63:0]  s;
        logic [63:0]  cl;
        logic [63:0]  res;
        int           w;
        int           vl;
        w  = width_of(e);
        vl = (v == 2'd0) ? 128 : (v == 2'd1) ? 256 : 512;
        r  = '0;
        for (int l = 0; l < 512 / w; l++) begin
            s  = 64'(d >> (l*w));
            cl = (bc && w != 16) ? 64'(c) : 64'(c >> (l*w));
            for (int b = w; b < 64; b++) begin
                s[b]  = s[w-1];
                cl[b] = 1'b0;
            end
            if (cl > 64'(w - 1))
                res = {64{s[w-1]}};
            else
                res = 64'($signed(s) >>> cl[5:0]);
            if (l*w >= vl)
                res = '0;
            else if (men && !m[l])
                res = zm ? 64'd0 : 64'(p >> (l*w));
            for (int b = 0; b < w; b++)
                r[l*w + b] = res[b];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fire(logic [1:0] e, logic [1:0] v, logic men, logic zm, logic bc,
                        logic [31:0] m, logic [511:0] d, logic [511:0] c, logic [511:0] p);
        @(negedge clk);
        elem_sel  = e;
        vlen_sel  = v;
        mask_en   = men;
        zero_mode = zm;
        bcast_en  = bc;
        lane_mask = m;
        data_in   = d;
        cnt_in    = c;
        prev_in   = p;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [511:0] d;
        logic [511:0] c;
        logic [511:0] p;
        logic [511:0] held;
        string        tag;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: state after reset
        chk("R11", 512'(out_valid), 512'd0);
        chk("R11", result, '0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            d = fill(64'(TBL[i].seed));
            c = mk_cnt(TBL[i].elem, 64'(TBL[i].seed), TBL[i].big);
            p = fill(64'(TBL[i].seed) + 64'd999);
            if (TBL[i].bc)
                tag = (TBL[i].elem == 2'd0) ? "R9" : "R8";
            else if (TBL[i].men)
                tag = TBL[i].zm ? "R6" : "R5";
            else if (TBL[i].big)
                tag = "R2";
            else if (TBL[i].vlen != 2'd2)
                tag = "R3";
            else
                tag = "R1";
            fire(TBL[i].elem, TBL[i].vlen, TBL[i].men, TBL[i].zm, TBL[i].bc, TBL[i].mask, d, c, p);
            chk("R10", 512'(out_valid), 512'd1);
            chk(tag, result, model(TBL[i].elem, TBL[i].vlen, TBL[i].men, TBL[i].zm,
                                   TBL[i].bc, TBL[i].mask, d, c, p));
        end

        // R1: hand value, 16-bit lane 0 = 0x8001 shifted by 1 -> 0xC000
        d = '0; c = '0; p = '0;
        d[15:0] = 16'h8001; c[15:0] = 16'd1;
        fire(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, d, c, p);
        chk("R1", 512'(result[15:0]), 512'(16'hC000));

        // R2: count 64 on positive lane -> 0; count with top bit on negative lane -> all ones
        d = '0; c = '0;
        d[63:0]    = 64'h7FFF_FFFF_FFFF_FFFF; c[63:0]   = 64'd64;
        d[127:64]  = 64'h8000_0000_0000_0001; c[127:64] = 64'h8000_0000_0000_0000;
        fire(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, d, c, p);
        chk("R2", 512'(result[127:0]), 512'({64'hFFFF_FFFF_FFFF_FFFF, 64'h0}));

        // R8: 32-bit broadcast of count 1 to lane 1 whose own count is 0
        d = '0; c = '0;
        d[63:32] = 32'h8000_0000; c[31:0] = 32'd1;
        fire(2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0, d, c, p);
        chk("R8", 512'(result[63:32]), 512'(32'hC000_0000));

        // R9: broadcast ignored for 16-bit lanes
        d = '0; c = '0;
        d[15:0] = 16'h8000; d[31:16] = 16'h8000; c[15:0] = 16'd4;
        fire(2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0, d, c, p);
        chk("R9", 512'(result[31:0]), 512'({16'h8000, 16'hF800}));

        // R4: mask disabled, mask bits all clear, every lane still shifted
        d = fill(64'd77); c = mk_cnt(2'd1, 64'd77, 1'b0); p = fill(64'd78);
        fire(2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0, d, c, p);
        chk("R4", result, model(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, d, c, p));

        // R7: mask bits above the two active 64-bit lanes are set; no effect
        d = fill(64'd81); c = mk_cnt(2'd2, 64'd81, 1'b0); p = fill(64'd82);
        fire(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFD, d, c, p);
        chk("R7", result, model(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0001, d, c, p));
        chk("R3", 512'(result[511:128]), 512'd0);

        // R12: inputs change without strobe, result holds, out_valid low
        held = result;
        @(negedge clk);
        data_in = fill(64'd90); cnt_in = '0; prev_in = fill(64'd91);
        mask_en = 1'b0; vlen_sel = 2'd2;
        repeat (3) @(negedge clk);
        chk("R12", result, held);
        chk("R10", 512'(out_valid), 512'd0);

        // R11: reset during operation clears the output
        fire(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, fill(64'd5), '0, '0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", result, '0);
        chk("R11", 512'(out_valid), 512'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule